// File: doc/BRIEF.md
# Level-Prioritized Interrupt Pending Logic

This block sits beside a processor core and decides whether the core should take an interrupt, and at which priority level. Interrupt sources reach it as raw lines. External request pins each map to one internal interrupt line through a parameter table, and timer-compare events do the same through a second table. A pending register collects the lines. A level-type line's pending bit follows its input. An edge-type line's pending bit is set on a rising edge and stays set until software clears it through a write-one-to-clear port.

A line competes for service only when both its pending bit and its enable bit are set. Each priority level owns a parameter mask of lines. The arbiter scans the levels from the highest configured one downward. It reports the first level whose mask holds an eligible line, but it only looks at levels strictly above the core's current interrupt level. The result is registered. The request flag and the level number therefore reflect the inputs present at the previous clock edge.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A level-type line (its `LINE_EDGE` bit is 0) has a pending bit equal to its raw input as sampled at the last clock edge, set while the input is high and cleared when it is low; the clear port has no effect on it.
- R2: An edge-type line (its `LINE_EDGE` bit is 1) has its pending bit set on a 0-to-1 transition of its raw input, and the bit stays set after the input returns to 0.
- R3: A cycle with `clr_we_i` high clears every edge-type pending bit whose bit in `clr_mask_i` is 1; a rising edge on the same line in the same cycle leaves the bit set.
- R4: A cycle with `en_we_i` high loads `en_wdata_i` into the enable register; a line is eligible only when its pending and enable bits are both 1.
- R5: Level L (1 to `N_LEVELS`) owns the lines whose bits are set in `LEVEL_MASK[L-1]`; the reported level is the highest such L that has an eligible line.
- R6: Only levels strictly greater than `cur_level_i` are considered.
- R7: When no level qualifies, `irq_o` is 0 and `irq_level_o` is 0; otherwise `irq_o` is 1 and `irq_level_o` is the selected level.
- R8: `irq_o` and `irq_level_o` change one clock edge after any change of input lines, enable writes, clears or `cur_level_i`.
- R9: External input k drives line `EXT_MAP[k]` and timer channel j drives line `TIMER_MAP[j]`; sources that share a line are ORed.
- R10: A source whose map entry is at or above `N_LINES` drives no line and leaves all state and outputs unchanged.
- R11: Reset clears the pending bits, enable bits, edge history and both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ext_irq_i | input | N_EXT | External interrupt request pins |
| timer_hit_i | input | N_TIMERS | Timer-compare match events, one per channel |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | N_LINES | New enable mask |
| clr_we_i | input | 1 | Pending clear strobe |
| clr_mask_i | input | N_LINES | Write-one-to-clear mask for edge-type pending bits |
| cur_level_i | input | LVL_W | Core's current interrupt level |
| irq_o | output | 1 | Interrupt request to the core |
| irq_level_o | output | LVL_W | Selected priority level, 0 when no request |

## Verification
The bench builds the block with 8 lines, 3 levels, 6 external pins and 2 timer channels. One external pin maps outside the line range, and a timer shares a level-type line with an external pin. The small configuration makes the full product of every enable mask and every current level reachable over a fixed pending pattern. A long pseudo-random run then mixes edges, clears, enable writes and level changes, so that set-versus-clear collisions, shared sources and the ignored pin all occur many times.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    // Width of a line-number entry in the source maps
    localparam int unsigned MAP_W = 6;

    // Bits needed to hold 0 .. n
    function automatic int unsigned lvl_bits(input int unsigned n);
        int unsigned w;
        w = 1;
        while ((1 << w) <= n) begin
            w = w + 1;
        end
        return w;
    endfunction

endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
    import irq_prio_pkg::*;
#(
    parameter int unsigned N_LINES  = 12,
    parameter int unsigned N_EXT    = 8,
    parameter int unsigned N_TIMERS = 3,
    parameter logic [N_EXT-1:0][MAP_W-1:0]    EXT_MAP   = '0,
    parameter logic [N_TIMERS-1:0][MAP_W-1:0] TIMER_MAP = '0
) (
    input  logic [N_EXT-1:0]    ext_irq_i,
    input  logic [N_TIMERS-1:0] timer_hit_i,
    output logic [N_LINES-1:0]  raw_o
);

    // One OR tree per line; an entry at or past N_LINES never matches
    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
        logic [N_EXT-1:0]    ext_hit;
        logic [N_TIMERS-1:0] tmr_hit;

        always_comb begin
            for (int k = 0; k < N_EXT; k++) begin
                ext_hit[k] = ext_irq_i[k] && (EXT_MAP[k] == MAP_W'(gi));
            end
            for (int j = 0; j < N_TIMERS; j++) begin
                tmr_hit[j] = timer_hit_i[j] && (TIMER_MAP[j] == MAP_W'(gi));
            end
        end

        assign raw_o[gi] = (|ext_hit) | (|tmr_hit);
    end

endmodule

// File: rtl/irq_pend_next.sv
module irq_pend_next #(
    parameter int unsigned        N_LINES   = 12,
    parameter logic [N_LINES-1:0] LINE_EDGE = '0
) (
    input  logic [N_LINES-1:0] pend_q_i,
    input  logic [N_LINES-1:0] prev_q_i,
    input  logic [N_LINES-1:0] raw_i,
    input  logic               clr_we_i,
    input  logic [N_LINES-1:0] clr_mask_i,
    output logic [N_LINES-1:0] pend_d_o
);

    // Each line picks its update rule from the type vector
    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_bit
        if (LINE_EDGE[gi]) begin : g_edge
            logic rise;
            logic kill;
            assign rise = raw_i[gi] & ~prev_q_i[gi];
            assign kill = clr_we_i & clr_mask_i[gi];
            // a fresh rising edge outranks a same-cycle clear
            assign pend_d_o[gi] = rise | (pend_q_i[gi] & ~kill);
        end else begin : g_level
            assign pend_d_o[gi] = raw_i[gi];
        end
    end

endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb #(
    parameter int unsigned N_LINES  = 12,
    parameter int unsigned N_LEVELS = 5,
    parameter int unsigned LVL_W    = 3,
    parameter logic [N_LEVELS-1:0][N_LINES-1:0] LEVEL_MASK = '0
) (
    input  logic [N_LINES-1:0] elig_i,
    input  logic [LVL_W-1:0]   cur_level_i,
    output logic               req_o,
    output logic [LVL_W-1:0]   level_o
);

    logic [N_LEVELS:1] lvl_hit;

    // Per-level qualification: overlap with eligible set and above the core
    for (genvar gl = 1; gl <= N_LEVELS; gl++) begin : g_lvl
        assign lvl_hit[gl] = (|(LEVEL_MASK[gl-1] & elig_i)) &&
                             (LVL_W'(gl) > cur_level_i);
    end

    // Downward scan: the first hit from the top wins
    always_comb begin
        req_o   = 1'b0;
        level_o = '0;
        for (int l = N_LEVELS; l >= 1; l--) begin
            if (!req_o && lvl_hit[l]) begin
                req_o   = 1'b1;
                level_o = LVL_W'(l);
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int unsigned N_LINES  = 12,
    parameter int unsigned N_LEVELS = 5,
    parameter int unsigned N_EXT    = 8,
    parameter int unsigned N_TIMERS = 3,
    parameter logic [N_LINES-1:0] LINE_EDGE = 12'b0110_0100_0100,
    parameter logic [N_LEVELS-1:0][N_LINES-1:0] LEVEL_MASK =
        {12'h800, 12'h600, 12'h180, 12'h070, 12'h00F},
    parameter logic [N_EXT-1:0][MAP_W-1:0] EXT_MAP =
        {6'd11, 6'd10, 6'd8, 6'd7, 6'd4, 6'd3, 6'd1, 6'd0},
    parameter logic [N_TIMERS-1:0][MAP_W-1:0] TIMER_MAP =
        {6'd9, 6'd6, 6'd2},
    localparam int unsigned LVL_W = lvl_bits(N_LEVELS)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [N_EXT-1:0]    ext_irq_i,
    input  logic [N_TIMERS-1:0] timer_hit_i,
    input  logic                en_we_i,
    input  logic [N_LINES-1:0]  en_wdata_i,
    input  logic                clr_we_i,
    input  logic [N_LINES-1:0]  clr_mask_i,
    input  logic [LVL_W-1:0]    cur_level_i,
    output logic                irq_o,
    output logic [LVL_W-1:0]    irq_level_o
);

    typedef struct packed {
        logic [N_LINES-1:0] pend;
        logic [N_LINES-1:0] prev;
        logic [N_LINES-1:0] en;
        logic               irq;
        logic [LVL_W-1:0]   lvl;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] pend_nxt;
    logic [N_LINES-1:0] elig_nxt;
    logic               req_nxt;
    logic [LVL_W-1:0]   lvl_nxt;
    logic [N_LINES-1:0] pend_q;
    logic [N_LINES-1:0] en_q;

    irq_src_map #(
        .N_LINES   (N_LINES),
        .N_EXT     (N_EXT),
        .N_TIMERS  (N_TIMERS),
        .EXT_MAP   (EXT_MAP),
        .TIMER_MAP (TIMER_MAP)
    ) u_map (
        .ext_irq_i   (ext_irq_i),
        .timer_hit_i (timer_hit_i),
        .raw_o       (raw_lines)
    );

    irq_pend_next #(
        .N_LINES   (N_LINES),
        .LINE_EDGE (LINE_EDGE)
    ) u_pend (
        .pend_q_i   (st_q.pend),
        .prev_q_i   (st_q.prev),
        .raw_i      (raw_lines),
        .clr_we_i   (clr_we_i),
        .clr_mask_i (clr_mask_i),
        .pend_d_o   (pend_nxt)
    );

    // Arbitrate on next-state values so the outputs lag inputs by one edge
    irq_level_arb #(
        .N_LINES    (N_LINES),
        .N_LEVELS   (N_LEVELS),
        .LVL_W      (LVL_W),
        .LEVEL_MASK (LEVEL_MASK)
    ) u_arb (
        .elig_i      (elig_nxt),
        .cur_level_i (cur_level_i),
        .req_o       (req_nxt),
        .level_o     (lvl_nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_nxt;
        st_d.prev = raw_lines;
        if (en_we_i) begin
            st_d.en = en_wdata_i;
        end
        elig_nxt  = st_d.pend & st_d.en;
        st_d.irq  = req_nxt;
        st_d.lvl  = lvl_nxt;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q      = st_q.pend;
    assign en_q        = st_q.en;
    assign irq_o       = st_q.irq;
    assign irq_level_o = st_q.lvl;

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
    parameter int unsigned        N_LINES   = 12,
    parameter int unsigned        N_LEVELS  = 5,
    parameter int unsigned        LVL_W     = 3,
    parameter logic [N_LINES-1:0] LINE_EDGE = '0
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [LVL_W-1:0]   cur_level_i,
    input logic               irq_o,
    input logic [LVL_W-1:0]   irq_level_o,
    input logic               clr_we_i,
    input logic [N_LINES-1:0] clr_mask_i,
    input logic [N_LINES-1:0] pend_q,
    input logic [N_LINES-1:0] en_q,
    input logic [N_LINES-1:0] raw_lines
);

    p_level_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> ((pend_q & ~LINE_EDGE) == ($past(raw_lines) & ~LINE_EDGE)));

    p_edge_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |->
        (($past(pend_q) & LINE_EDGE & ~($past(clr_we_i) ? $past(clr_mask_i) : '0)
          & ~pend_q) == '0));

    p_req_needs_elig_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (|(pend_q & en_q)));

    p_level_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_level_o <= LVL_W'(N_LEVELS));

    p_above_core_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && irq_o) |-> (irq_level_o > $past(cur_level_i)));

    p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o |-> (irq_level_o == '0));

    p_reset_clear_r11: assert property (@(posedge clk_i)
        !rst_ni |=> (pend_q == '0 && en_q == '0 && !irq_o && irq_level_o == '0));

endmodule

bind irq_prio_ctrl irq_prio_chk #(
    .N_LINES   (N_LINES),
    .N_LEVELS  (N_LEVELS),
    .LVL_W     (LVL_W),
    .LINE_EDGE (LINE_EDGE)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cur_level_i (cur_level_i),
    .irq_o       (irq_o),
    .irq_level_o (irq_level_o),
    .clr_we_i    (clr_we_i),
    .clr_mask_i  (clr_mask_i),
    .pend_q      (pend_q),
    .en_q        (en_q),
    .raw_lines   (raw_lines)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;

    localparam int unsigned NL = 8;
    localparam int unsigned NV = 3;
    localparam int unsigned NE = 6;
    localparam int unsigned NT = 2;
    localparam int unsigned LW = 2;
    localparam logic [NL-1:0] EDGE = 8'b1010_0110;          // lines 1,2,5,7 edge
    localparam logic [NV-1:0][NL-1:0] LMASK = {8'hE0, 8'h1C, 8'h03};
    localparam logic [NE-1:0][5:0] EMAP = {6'd15, 6'd4, 6'd3, 6'd2, 6'd1, 6'd0};
    localparam logic [NT-1:0][5:0] TMAP = {6'd3, 6'd5};     // timer1 shares line 3

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] ext = '0;
    logic [NT-1:0] tmr = '0;
    logic          en_we = 1'b0;
    logic [NL-1:0] en_wd = '0;
    logic          clr_we = 1'b0;
    logic [NL-1:0] clr_m = '0;
    logic [LW-1:0] cur = '0;
    logic          irq;
    logic [LW-1:0] lvl;

    int n_vec  = 0;
    int n_miss = 0;

    logic [NL-1:0] m_pend = '0;
    logic [NL-1:0] m_prev = '0;
    logic [NL-1:0] m_en   = '0;

    always #10 clk = ~clk;

    irq_prio_ctrl #(
        .N_LINES    (NL),
        .N_LEVELS   (NV),
        .N_EXT      (NE),
        .N_TIMERS   (NT),
        .LINE_EDGE  (EDGE),
        .LEVEL_MASK (LMASK),
        .EXT_MAP    (EMAP),
        .TIMER_MAP  (TMAP)
    ) i_irq_prio_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ext_irq_i   (ext),
        .timer_hit_i (tmr),
        .en_we_i     (en_we),
        .en_wdata_i  (en_wd),
        .clr_we_i    (clr_we),
        .clr_mask_i  (clr_m),
        .cur_level_i (cur),
        .irq_o       (irq),
        .irq_level_o (lvl)
    );

    function automatic logic [NL-1:0] raw_of(input logic [NE-1:0] e, input logic [NT-1:0] t);
        logic [NL-1:0] r;
        r = '0;
        for (int k = 0; k < NE; k++) if (e[k] && EMAP[k] < NL) r[EMAP[k][2:0]] = 1'b1;
        for (int j = 0; j < NT; j++) if (t[j] && TMAP[j] < NL) r[TMAP[j][2:0]] = 1'b1;
        return r;
    endfunction

    function automatic int pick(input logic [NL-1:0] elig, input int c);
        for (int l = NV; l >= 1; l--) begin
            if (l > c && (LMASK[l-1] & elig) != '0) return l;
        end
        return 0;
    endfunction

    // Called just after a falling edge with inputs already driven
    task automatic step(input string tag);
        logic [NL-1:0] r, pn, en_n;
        int exp_l;
        r  = raw_of(ext, tmr);
        for (int i = 0; i < NL; i++) begin
            if (EDGE[i])
                pn[i] = (r[i] & ~m_prev[i]) | (m_pend[i] & ~(clr_we & clr_m[i]));
            else
                pn[i] = r[i];
        end
        en_n  = en_we ? en_wd : m_en;
        exp_l = pick(pn & en_n, int'(cur));
        @(negedge clk);
        n_vec++;
        if (irq !== (exp_l != 0) || int'(lvl) !== exp_l) begin
            n_miss++;
            $display("FAIL %s: irq=%0b level=%0d expected irq=%0b level=%0d",
                     tag, irq, lvl, (exp_l != 0), exp_l);
        end
        m_pend = pn;
        m_prev = r;
        m_en   = en_n;
    endtask

    task automatic quiet();
        en_we  = 1'b0;
        clr_we = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_miss++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        step("R11 reset");

        // R4: enable all lines, core at 0
        en_we = 1'b1; en_wd = 8'hFF; step("R4 enable write"); quiet();
        // R1: level line 0 follows its pin
        ext[0] = 1'b1; step("R1 level set");
        step("R1 level hold");
        ext[0] = 1'b0; step("R1 level drop");
        clr_we = 1'b1; clr_m = 8'h01; ext[0] = 1'b1; step("R1 clear ignored"); quiet();
        ext[0] = 1'b0; step("R1 level drop2");
        // R2: edge line 1 latches a pulse
        ext[1] = 1'b1; step("R2 edge set");
        ext[1] = 1'b0; step("R2 edge sticky");
        step("R2 edge sticky2");
        // R3: clear acknowledges it; same-cycle rise wins
        clr_we = 1'b1; clr_m = 8'h02; step("R3 clear"); quiet();
        ext[1] = 1'b1; clr_we = 1'b1; clr_m = 8'h02; step("R3 rise beats clear"); quiet();
        ext[1] = 1'b0; step("R3 still set");
        clr_we = 1'b1; clr_m = 8'hFF; step("R3 clear all"); quiet();
        // R9: timer0 to edge line 5 (level 3), timer1 shares level line 3
        tmr[0] = 1'b1; step("R9 timer edge");
        tmr[0] = 1'b0; cur = 2'd3; step("R6 masked by core level");
        cur = 2'd2; step("R6 core below");
        clr_we = 1'b1; clr_m = 8'h20; cur = 2'd0; step("R9 ack timer"); quiet();
        tmr[1] = 1'b1; step("R9 shared timer");
        ext[3] = 1'b1; tmr[1] = 1'b0; step("R9 shared ext");
        ext[3] = 1'b0; step("R9 shared drop");
        // R10: unmapped pin
        ext[5] = 1'b1; step("R10 unmapped high");
        ext[5] = 1'b0; step("R10 unmapped low");
        // R5: level 1 and level 2 together
        ext[0] = 1'b1; ext[4] = 1'b1; step("R5 two levels");
        cur = 2'd1; step("R6 level1 hidden");
        cur = 2'd0; ext = '0; step("R7 idle");

        // Sweep enable x core level over a fixed pending pattern
        ext = 6'b011111; tmr = 2'b01; step("R5 setup");
        for (int e = 0; e < 256; e++) begin
            for (int c = 0; c < 4; c++) begin
                en_we = 1'b1; en_wd = NL'(e); cur = LW'(c);
                step("R5/R6 sweep");
            end
        end
        quiet();
        ext = '0; tmr = '0; clr_we = 1'b1; clr_m = 8'hFF; step("R7 cleared"); quiet();

        // Pseudo-random traffic, one check per cycle
        seed = 32'h1234_5678;
        for (int n = 0; n < 6000; n++) begin
            seed   = seed * 32'd1664525 + 32'd1013904223;
            ext    = seed[13:8];
            tmr    = seed[15:14];
            en_we  = (seed[19:16] == 4'd0);
            en_wd  = seed[27:20];
            clr_we = seed[28];
            clr_m  = seed[31:24] ^ seed[7:0];
            cur    = seed[30:29];
            step("R8 random");
        end
        quiet();

        // R11: reset mid-activity
        ext = 6'b111111; step("R11 pre");
        rst_n = 1'b0; ext = '0; tmr = '0;
        @(negedge clk);
        rst_n = 1'b1;
        m_pend = '0; m_prev = '0; m_en = '0;
        step("R11 after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule